// File: doc/BRIEF.md
# Tearing-Effect Frame Write Gate

This block decides when a display frame write may begin. An upstream agent asks for a frame with a one-cycle request. The gate waits for a trigger chosen by a mode input before it launches the frame. The trigger can be the rising edge of the panel's tearing-effect (TE) line, its falling edge, or no TE wait at all. The TE line is asynchronous, so it passes through a synchroniser before edge detection. When the trigger arrives, the gate pulses a start strobe to the downstream transmitter and drives the active-low chip select. Chip select stays low until the transmitter reports completion.

Falling-edge operation is only safe when the frame finishes before the panel has scanned out two full frames. Otherwise the panel's read pointer overtakes the write pointer. The gate therefore counts falling TE edges during a frame and raises a sticky overrun flag when a second one arrives. A request that arrives while a frame is in flight is remembered and served at the next trigger after that frame ends.

Top module: `te_frame_gate`

## Requirements
- R1: After reset, `cs_n_o` is 1, `tx_start_o` is 0 and `overrun_o` is 0.
- R2: With `mode_i` = 0 (no TE wait), a request sampled at clock edge j starts a frame at edge j+1: `tx_start_o` is 1 and `cs_n_o` is 0 after that edge.
- R3: With `mode_i` = 1 (rising edge), suppose `te_i` is first sampled high at edge k after being low at k-1. A frame then starts at edge k+2 if a request was sampled at or before edge k+1. No frame starts in this mode except at that point after a rising edge.
- R4: With `mode_i` = 2 (falling edge), the rule of R3 applies with a falling edge of `te_i` in place of a rising one.
- R5: `cs_n_o` goes low at the start edge and stays low through every edge at which `tx_done_i` is 0. It returns to 1 after the first edge that samples `tx_done_i` = 1 while a frame is active. `tx_done_i` has no effect while no frame is active.
- R6: `tx_start_o` is high for exactly one cycle per frame, and only when `cs_n_o` is low.
- R7: A request sampled while a frame is active, including at the start edge, is held. It launches a new frame only at the first qualifying trigger after the current frame has ended, and never during the current frame.
- R8: In mode 2, a second falling TE edge detected while the frame is still active sets `overrun_o`. The start edge does not count. `overrun_o` stays set until the next frame start, which clears it.
- R9: In modes 0 and 1, `overrun_o` never becomes set.
- R10: `mode_i` = 3 is reserved. It never starts a frame, and any request stays pending.
- R11: A TE edge that arrives with no pending request starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Trigger select: 0 none, 1 rising TE, 2 falling TE, 3 reserved |
| te_i | input | 1 | Asynchronous tearing-effect line from the panel |
| req_i | input | 1 | Frame request, sampled each clock |
| tx_done_i | input | 1 | Transmitter reports the frame is complete |
| tx_start_o | output | 1 | One-cycle launch strobe to the transmitter |
| cs_n_o | output | 1 | Active-low chip select, held for the whole frame |
| overrun_o | output | 1 | Sticky flag: frame outlasted two panel scans in falling mode |

## Verification
The bench measures the exact synchroniser latency from a TE transition to the start strobe. A gate that skips a flop, or adds one, shows the strobe a cycle early or late. It checks that edges of the wrong polarity, and edges arriving with no request, launch nothing. A polarity swap or a missing request qualifier would produce a spurious frame. It also checks that a request made mid-frame waits for a fresh trigger instead of restarting as soon as the frame ends. For the overrun counter, it checks that the start edge is not counted, that the flag survives the end of the frame, and that the next launch clears it. An off-by-one counter would flag one TE period too early, and a non-sticky flag would vanish at completion.

// File: rtl/tefg_pkg.sv
package tefg_pkg;

  typedef enum logic [1:0] {
    TRIG_NONE = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_RSVD = 2'd3
  } trig_mode_e;

  typedef enum logic {
    PH_IDLE   = 1'b0,
    PH_ACTIVE = 1'b1
  } gate_phase_e;

  // Decide whether this cycle's detected events satisfy the selected mode.
  function automatic logic trigger_met(input logic [1:0] mode,
                                       input logic rise_ev,
                                       input logic fall_ev);
    logic hit;
    unique case (mode)
      TRIG_NONE: hit = 1'b1;
      TRIG_RISE: hit = rise_ev;
      TRIG_FALL: hit = fall_ev;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction

  // Saturating increment for the in-frame falling-edge counter.
  function automatic logic [7:0] sat_inc(input logic [7:0] value,
                                         input logic [7:0] ceiling);
    return (value >= ceiling) ? ceiling : value + 8'd1;
  endfunction

endpackage

// File: rtl/tefg_sync.sv
module tefg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int CHAIN = STAGES + 1;

  logic [CHAIN-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[CHAIN-2:0], async_i};
  end

  logic level_now, level_prev;
  assign level_now  = chain_q[STAGES-1];
  assign level_prev = chain_q[STAGES];

  assign rise_o = level_now & ~level_prev;
  assign fall_o = ~level_now & level_prev;
endmodule

// File: rtl/tefg_sequencer.sv
module tefg_sequencer
  import tefg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       req_i,
  input  logic       done_i,
  input  logic       rise_i,
  input  logic       fall_i,
  output logic       launch_o,
  output logic       active_o,
  output logic       start_o
);
  gate_phase_e phase_q;
  logic        pend_q;

  assign launch_o = (phase_q == PH_IDLE) && pend_q && trigger_met(mode_i, rise_i, fall_i);
  assign active_o = (phase_q == PH_ACTIVE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      pend_q  <= 1'b0;
      start_o <= 1'b0;
    end else begin
      start_o <= launch_o;
      if (launch_o) begin
        phase_q <= PH_ACTIVE;
        pend_q  <= req_i;
      end else begin
        if (phase_q == PH_ACTIVE && done_i) phase_q <= PH_IDLE;
        if (req_i) pend_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tefg_overrun.sv
module tefg_overrun
  import tefg_pkg::*;
#(
  parameter int FALL_LIMIT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       launch_i,
  input  logic       active_i,
  input  logic       fall_i,
  output logic       overrun_o
);
  localparam logic [7:0] LIMIT = 8'(FALL_LIMIT);

  logic [7:0] falls_q;
  logic [7:0] falls_nx;
  logic       count_ev;

  assign count_ev = active_i && fall_i && (mode_i == TRIG_FALL);
  assign falls_nx = sat_inc(falls_q, LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      falls_q   <= '0;
      overrun_o <= 1'b0;
    end else if (launch_i) begin
      falls_q   <= '0;
      overrun_o <= 1'b0;
    end else if (count_ev) begin
      falls_q <= falls_nx;
      if (falls_nx == LIMIT) overrun_o <= 1'b1;
    end
  end
endmodule

// File: rtl/te_frame_gate.sv
module te_frame_gate
  import tefg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FALL_LIMIT  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       te_i,
  input  logic       req_i,
  input  logic       tx_done_i,
  output logic       tx_start_o,
  output logic       cs_n_o,
  output logic       overrun_o
);
  logic rise_w, fall_w, launch_w, active_w;

  tefg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(te_i),
    .rise_o(rise_w), .fall_o(fall_w)
  );

  tefg_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .req_i(req_i),
    .done_i(tx_done_i), .rise_i(rise_w), .fall_i(fall_w),
    .launch_o(launch_w), .active_o(active_w), .start_o(tx_start_o)
  );

  tefg_overrun #(.FALL_LIMIT(FALL_LIMIT)) u_ovr (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .launch_i(launch_w),
    .active_i(active_w), .fall_i(fall_w), .overrun_o(overrun_o)
  );

  assign cs_n_o = ~active_w;
endmodule

// File: rtl/tefg_checker.sv
module tefg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_i,
  input logic       tx_done_i,
  input logic       tx_start_o,
  input logic       cs_n_o,
  input logic       overrun_o,
  input logic       launch,
  input logic       rise_evt,
  input logic       fall_evt
);
  p_start_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start_o |=> !tx_start_o);

  p_start_with_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start_o |-> !cs_n_o);

  p_cs_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && !tx_done_i) |=> !cs_n_o);

  p_cs_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && tx_done_i) |=> cs_n_o);

  p_rise_trigger_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && mode_i == 2'd1) |-> rise_evt);

  p_fall_trigger_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && mode_i == 2'd2) |-> fall_evt);

  p_reserved_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd3) |-> !launch);

  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_o && !launch) |=> overrun_o);

  p_overrun_fall_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun_o) |-> ($past(mode_i) == 2'd2));
endmodule

bind te_frame_gate tefg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .tx_done_i(tx_done_i),
  .tx_start_o(tx_start_o), .cs_n_o(cs_n_o), .overrun_o(overrun_o),
  .launch(launch_w), .rise_evt(rise_w), .fall_evt(fall_w)
);

// File: tb/te_frame_gate_test.sv
`timescale 1ns/1ps
module te_frame_gate_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic te = 1'b0, req = 1'b0, done = 1'b0;
  logic start, cs_n, ovr;

  always #4 clk = ~clk;

  te_frame_gate uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .te_i(te), .req_i(req),
    .tx_done_i(done), .tx_start_o(start), .cs_n_o(cs_n), .overrun_o(ovr)
  );

  int n_cmp = 0, n_bad = 0, cycles = 0;

  // reference state
  logic a1 = 0, a2 = 0, a3 = 0;
  logic m_act = 0, m_pend = 0, m_start = 0, m_ovr = 0;
  int   m_falls = 0;

  function automatic bit fires(input logic [1:0] md, input logic up, input logic dn);
    if (md == 2'd0) return 1'b1;
    if (md == 2'd1) return up;
    if (md == 2'd2) return dn;
    return 1'b0;
  endfunction

  function automatic string start_tag(input logic [1:0] md);
    case (md)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic up, dn, old_act, go;
    up = a2 & ~a3;
    dn = ~a2 & a3;
    old_act = m_act;
    go = !m_act && m_pend && fires(mode, up, dn);
    m_start = go;
    if (go) begin
      m_act = 1; m_pend = req; m_falls = 0; m_ovr = 0;
    end else begin
      if (m_act && done) m_act = 0;
      if (req) m_pend = 1;
      if (old_act && dn && mode == 2'd2) begin
        if (m_falls < 2) m_falls++;
        if (m_falls == 2) m_ovr = 1;
      end
    end
    a3 = a2; a2 = a1; a1 = te;
  endtask

  task automatic tick();
    @(posedge clk);
    #1 model_edge();
    @(negedge clk);
    check(cs_n == !m_act, "R5", cs_n, !m_act);
    check(start == m_start, start_tag(mode), start, m_start);
    check(ovr == m_ovr, (mode == 2'd2) ? "R8" : "R9", ovr, m_ovr);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic pulse_req();
    req = 1; tick(); req = 0;
  endtask

  task automatic pulse_done();
    done = 1; tick(); done = 0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    finish_run();
  end

  initial begin : main
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset values
    check(cs_n == 1 && start == 0 && ovr == 0, "R1", {cs_n, start, ovr}, 3'b100);

    // R11: rising edge without a request
    mode = 2'd1;
    te = 1; ticks(5);
    check(cs_n == 1, "R11", cs_n, 1);
    te = 0; ticks(5);

    // R3: exact synchroniser latency
    pulse_req(); ticks(3);
    te = 1; ticks(2);
    check(start == 0, "R3", start, 0);
    tick();
    check(start == 1 && cs_n == 0, "R3", {start, cs_n}, 2'b10);
    tick();
    check(start == 0, "R6", start, 0);
    ticks(4);
    check(cs_n == 0, "R5", cs_n, 0);
    pulse_done();
    check(cs_n == 1, "R5", cs_n, 1);
    done = 1; ticks(2); done = 0;  // done while idle
    check(cs_n == 1 && start == 0, "R5", {cs_n, start}, 2'b10);

    // R7: request during active waits for the next trigger
    pulse_req();
    te = 0; ticks(4);
    te = 1; ticks(3);
    check(start == 1, "R3", start, 1);
    tick(); pulse_req(); ticks(2);
    pulse_done(); ticks(4);
    check(cs_n == 1, "R7", cs_n, 1);
    te = 0; ticks(5);
    check(cs_n == 1, "R7", cs_n, 1);
    te = 1; ticks(3);
    check(start == 1, "R7", start, 1);
    pulse_done();

    // R4/R8: falling mode and overrun
    mode = 2'd2;
    pulse_req();
    te = 0; ticks(3);
    check(start == 1, "R4", start, 1);
    te = 1; ticks(4); te = 0; ticks(3);
    check(ovr == 0, "R8", ovr, 0);
    te = 1; ticks(4); te = 0; ticks(3);
    check(ovr == 1, "R8", ovr, 1);
    pulse_done(); ticks(3);
    check(ovr == 1, "R8", ovr, 1);
    pulse_req();
    te = 1; ticks(4); te = 0; ticks(3);
    check(start == 1 && ovr == 0, "R8", {start, ovr}, 2'b10);
    pulse_done();

    // R2: no TE wait
    mode = 2'd0;
    req = 1; tick(); req = 0;
    tick();
    check(start == 1 && cs_n == 0, "R2", {start, cs_n}, 2'b10);
    ticks(2); pulse_done();

    // R10: reserved mode holds the request
    mode = 2'd3;
    pulse_req();
    for (int k = 0; k < 4; k++) begin te = ~te; ticks(4); end
    check(cs_n == 1, "R10", cs_n, 1);
    mode = 2'd0; tick();
    check(start == 1, "R10", start, 1);

    // R9: long frame in rising mode never flags
    mode = 2'd1;
    for (int k = 0; k < 6; k++) begin te = ~te; ticks(5); end
    check(ovr == 0, "R9", ovr, 0);
    pulse_done();

    // random phase across all modes
    begin
      int left = 20;
      for (int seg = 0; seg < 8; seg++) begin
        mode = 2'(seg % 4);
        for (int c = 0; c < 2500; c++) begin
          if (left == 0) begin te = ~te; left = $urandom_range(45, 15); end
          else left--;
          req  = ($urandom_range(24, 0) == 0);
          done = m_act ? ($urandom_range(59, 0) == 0) : ($urandom_range(7, 0) == 0);
          tick();
        end
      end
      req = 0; done = 0;
    end

    finish_run();
  end
endmodule